// File: doc/BRIEF.md
# Frequency Synthesizer Divider and Phase/Frequency Detector

This block is the digital core of a frequency synthesizer loop. A programmable counter divides the oscillator input by a ratio N between 1024 and 2047. A fixed counter divides a crystal clock by 400 to give a 10 kHz comparison reference. A phase/frequency detector watches the falling edges of the two divided signals. It issues a source command, a sink command, or neither to an external charge pump. A software bit selects the pump current scale, 1 or 5. A lock flag reports that the loop has been quiet for a set number of reference periods.

Everything runs on one system clock. The oscillator and the crystal arrive as single-cycle enable pulses (`vco_tick`, `xtal_tick`), one per period of the signal they stand for. Every command is therefore measured in whole system-clock cycles. The block has no streaming data path, so it has no valid/ready handshake. All pins are plain control and status levels: they are sampled at every rising clock edge and updated at every rising clock edge.

Top module: `synth_core`

## Requirements
- R1: `div_vco` falls exactly once every N `vco_tick` pulses. The falling edge occurs at the rising clock edge that takes the N-th pulse of the interval.
- R2: `n_word` is an 11-bit unsigned ratio. Any value below 1024 is used as 1024. Values from 1024 to 2047 are used as given.
- R3: A new ratio takes effect only at the end of an interval. The interval in progress keeps its ratio. The value on `n_word` at the clock edge that ends an interval sets the length of the next interval. The first interval after reset is 1024 pulses long.
- R4: `div_ref` falls exactly once every 400 `xtal_tick` pulses.
- R5: If `div_vco` falls before `div_ref`, `pump_up` goes high at the edge where `div_vco` falls. It stays high until the edge where `div_ref` falls, so its width in clock cycles equals the lead.
- R6: If `div_ref` falls before `div_vco`, `pump_dn` is high from the edge where `div_ref` falls until the edge where `div_vco` falls, so its width in clock cycles equals the lag.
- R7: If both divided signals fall at the same clock edge, neither command is asserted.
- R8: `pump_up` and `pump_dn` are never high in the same cycle.
- R9: `pump_mag` is the 3-bit pump current scale. It is 5 while `cur_hi` is 1 and 1 while `cur_hi` is 0.
- R10: `pump_hiz` is 1 exactly when neither `pump_up` nor `pump_dn` is high.
- R11: A falling edge of `div_ref` counts toward lock only if neither command was high in the cycle before it. `locked` rises once 16 such edges have occurred in a row. Any command clears the count and drops `locked` at the next clock edge.
- R12: While `rst_n` is low, all of the following hold: both divided outputs are 0, no command is asserted, `pump_hiz` is 1, `locked` is 0, and the active ratio is 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vco_tick | input | 1 | One pulse per oscillator period |
| xtal_tick | input | 1 | One pulse per crystal period |
| n_word | input | 11 | Requested oscillator divide ratio |
| cur_hi | input | 1 | Pump current scale select (1 selects scale 5) |
| div_vco | output | 1 | Divided oscillator waveform |
| div_ref | output | 1 | Divided crystal reference waveform |
| pump_up | output | 1 | Charge pump source command |
| pump_dn | output | 1 | Charge pump sink command |
| pump_hiz | output | 1 | Pump output high-impedance |
| pump_mag | output | 3 | Pump current scale, 1 or 5 |
| locked | output | 1 | Loop lock indication |

## Verification
A ratio latched at the wrong moment, or a divider count that runs past its limit, shows up as a wrong tick count between two falls of `div_vco` or `div_ref`. The error is visible at the first affected falling edge. A detector flop that fails to set or clear shows up as a command pulse whose width does not match the edge gap. Commands that overlap, or that fire on coincident edges, also expose such a fault, at the latest by the next reference edge. A lock counter that is off by one moves the rise of `locked` by one full reference period. Failing to clear the counter leaves `locked` high one cycle after a command has started.

// File: rtl/synth_pkg.sv
package synth_pkg;

  localparam int N_W       = 11;
  localparam int N_MIN     = 1024;
  localparam int REF_DIV   = 400;
  localparam int LOCK_REFS = 16;
  localparam int MAG_W     = 3;
  localparam int MAG_LO    = 1;
  localparam int MAG_HI    = 5;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_cmd_t;

endpackage

// File: rtl/div_counter.sv
module div_counter #(
  parameter int CNT_W        = 11,
  parameter bit PROGRAMMABLE = 1'b1,
  parameter int FLOOR_N      = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] n_req,
  output logic             div_out,
  output logic             fall
);

  localparam logic [CNT_W-1:0] FLOOR_V = CNT_W'(FLOOR_N);

  logic [CNT_W-1:0] n_act;
  logic [CNT_W-1:0] cnt;
  logic             tc;

  assign tc   = (cnt == n_act - 1'b1);
  assign fall = tick && tc;

  generate
    if (PROGRAMMABLE) begin : g_prog
      logic [CNT_W-1:0] n_clamped;
      assign n_clamped = (n_req < FLOOR_V) ? FLOOR_V : n_req;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          n_act <= FLOOR_V;
        else if (tick && tc) n_act <= n_clamped;
      end

      // ratio changes only at an interval end (R3)
      assert_load_at_tc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(n_act) |-> $past(tick && tc));

      // active ratio never under the floor (R2)
      assert_n_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        n_act >= FLOOR_V);
    end else begin : g_fixed
      assign n_act = n_req;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_out <= 1'b0;
    end else if (tick) begin
      if (tc) begin
        cnt     <= '0;
        div_out <= 1'b0;
      end else begin
        cnt     <= cnt + 1'b1;
        div_out <= ((cnt + 1'b1) >= (n_act >> 1));
      end
    end
  end

  // count stays inside the active ratio (R1)
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < n_act);

endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import synth_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      vco_fall,
  input  logic      ref_fall,
  output pump_cmd_t cmd
);

  logic up_q, dn_q;
  logic set_up, set_dn, both;

  assign set_up = up_q | vco_fall;
  assign set_dn = dn_q | ref_fall;
  assign both   = set_up & set_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= set_up & ~both;
      dn_q <= set_dn & ~both;
    end
  end

  assign cmd.up = up_q;
  assign cmd.dn = dn_q;

  assert_never_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q));

  assert_coincide_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vco_fall && ref_fall && !up_q && !dn_q) |=> (!up_q && !dn_q));

  assert_up_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !ref_fall) |=> up_q);

  assert_dn_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_q && !vco_fall) |=> dn_q);

  assert_up_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && ref_fall) |=> !up_q);

endmodule

// File: rtl/lock_detect.sv
module lock_detect #(
  parameter int LOCK_REFS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_fall,
  input  logic pulse_active,
  output logic locked
);

  localparam int CW = $clog2(LOCK_REFS + 1);
  localparam logic [CW-1:0] LOCK_V = CW'(LOCK_REFS);

  logic [CW-1:0] quiet_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               quiet_cnt <= '0;
    else if (pulse_active)                    quiet_cnt <= '0;
    else if (ref_fall && quiet_cnt < LOCK_V)  quiet_cnt <= quiet_cnt + 1'b1;
  end

  assign locked = (quiet_cnt == LOCK_V);

  assert_lock_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_active |=> !locked);

  assert_lock_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ref_fall));

endmodule

// File: rtl/synth_core.sv
module synth_core
  import synth_pkg::*;
#(
  parameter int P_N_W       = N_W,
  parameter int P_N_MIN     = N_MIN,
  parameter int P_REF_DIV   = REF_DIV,
  parameter int P_LOCK_REFS = LOCK_REFS,
  parameter int P_MAG_W     = MAG_W,
  parameter int P_MAG_LO    = MAG_LO,
  parameter int P_MAG_HI    = MAG_HI
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vco_tick,
  input  logic               xtal_tick,
  input  logic [P_N_W-1:0]   n_word,
  input  logic               cur_hi,
  output logic               div_vco,
  output logic               div_ref,
  output logic               pump_up,
  output logic               pump_dn,
  output logic               pump_hiz,
  output logic [P_MAG_W-1:0] pump_mag,
  output logic               locked
);

  localparam int REF_W = $clog2(P_REF_DIV + 1);
  localparam logic [REF_W-1:0] REF_V = REF_W'(P_REF_DIV);

  logic      vco_fall, ref_fall;
  pump_cmd_t cmd;

  div_counter #(
    .CNT_W(P_N_W), .PROGRAMMABLE(1'b1), .FLOOR_N(P_N_MIN)
  ) u_vco_div (
    .clk(clk), .rst_n(rst_n), .tick(vco_tick), .n_req(n_word),
    .div_out(div_vco), .fall(vco_fall)
  );

  div_counter #(
    .CNT_W(REF_W), .PROGRAMMABLE(1'b0), .FLOOR_N(1)
  ) u_ref_div (
    .clk(clk), .rst_n(rst_n), .tick(xtal_tick), .n_req(REF_V),
    .div_out(div_ref), .fall(ref_fall)
  );

  pfd_core u_pfd (
    .clk(clk), .rst_n(rst_n), .vco_fall(vco_fall), .ref_fall(ref_fall), .cmd(cmd)
  );

  lock_detect #(.LOCK_REFS(P_LOCK_REFS)) u_lock (
    .clk(clk), .rst_n(rst_n), .ref_fall(ref_fall),
    .pulse_active(cmd.up | cmd.dn), .locked(locked)
  );

  assign pump_up  = cmd.up;
  assign pump_dn  = cmd.dn;
  assign pump_hiz = ~(cmd.up | cmd.dn);
  assign pump_mag = cur_hi ? P_MAG_W'(P_MAG_HI) : P_MAG_W'(P_MAG_LO);

endmodule

// File: tb/tb_synth_core.sv
`timescale 1ns/1ps
module tb_synth_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vco_tick = 1'b0, xtal_tick = 1'b0, cur_hi = 1'b0;
  logic [10:0] n_word = 11'd1024;
  logic        div_vco, div_ref, pump_up, pump_dn, pump_hiz, locked;
  logic [2:0]  pump_mag;

  always #2.5 clk = ~clk;

  synth_core dut (
    .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .xtal_tick(xtal_tick),
    .n_word(n_word), .cur_hi(cur_hi), .div_vco(div_vco), .div_ref(div_ref),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
    .pump_mag(pump_mag), .locked(locked)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // monitor state
  bit prev_dv = 0, prev_dr = 0, prev_up = 0, prev_pulse = 0;
  bit eu = 0, ed = 0;
  int ecnt = 0, exp_n = 1024, vt_cnt = 0, xt_cnt = 0;
  int up_w = 0, dn_w = 0, up_end_w = 0, dn_end_w = 0;
  bit up_end = 0, dn_end = 0, prev_dn = 0;
  int vf_seen = 0, rf_seen = 0, pulses_seen = 0;

  // drive state
  int mode = 0;       // 0 random, 1 fixed-rate
  int stall_left = 0, xph = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int nclamp(input int n);
    return (n < 1024) ? 1024 : n;
  endfunction

  task automatic monitor();
    bit vf, rf, nu, nd;
    vf = prev_dv && !div_vco;
    rf = prev_dr && !div_ref;
    if (vco_tick) vt_cnt++;
    if (xtal_tick) xt_cnt++;
    if (vf) begin
      chk(vt_cnt == exp_n, "R1 R3 vco interval", vt_cnt, exp_n);
      exp_n = nclamp(int'(n_word));  // R2 clamp, R3 value at interval end
      vt_cnt = 0;
      vf_seen++;
    end
    if (rf) begin
      chk(xt_cnt == 400, "R4 ref interval", xt_cnt, 400);
      xt_cnt = 0;
      rf_seen++;
    end
    nu = eu | vf; nd = ed | rf;
    if (nu && nd) begin eu = 0; ed = 0; end
    else begin eu = nu; ed = nd; end
    chk(pump_up == eu, "R5 R7 pump_up", pump_up, eu);
    chk(pump_dn == ed, "R6 R7 pump_dn", pump_dn, ed);
    chk(!(pump_up && pump_dn), "R8 exclusive", {pump_up, pump_dn}, 0);
    chk(pump_hiz == !(pump_up || pump_dn), "R10 hiz", pump_hiz, !(pump_up || pump_dn));
    chk(pump_mag == (cur_hi ? 3'd5 : 3'd1), "R9 mag", pump_mag, cur_hi ? 5 : 1);
    if (prev_pulse) ecnt = 0;
    else if (rf && ecnt < 16) ecnt++;
    chk(locked == (ecnt == 16), "R11 locked", locked, ecnt == 16);
    if (pump_up) up_w++;
    else if (prev_up) begin up_end_w = up_w; up_end = 1; up_w = 0; end
    if (pump_dn) dn_w++;
    else if (prev_dn) begin dn_end_w = dn_w; dn_end = 1; dn_w = 0; end
    if ((pump_up || pump_dn) && !prev_pulse) pulses_seen++;
    prev_dv = div_vco; prev_dr = div_ref;
    prev_up = pump_up; prev_dn = pump_dn; prev_pulse = pump_up || pump_dn;
  endtask

  task automatic step();
    @(negedge clk);
    monitor();
    if (mode == 0) begin
      vco_tick  = ($urandom_range(0, 3) != 0);
      xtal_tick = $urandom_range(0, 1);
      if ($urandom_range(0, 2999) == 0) begin
        case ($urandom_range(0, 4))
          0: n_word = 11'd0;
          1: n_word = 11'd1023;
          2: n_word = 11'd2047;
          3: n_word = 11'd1024;
          default: n_word = 11'($urandom_range(0, 2047));
        endcase
      end
      if ($urandom_range(0, 499) == 0) cur_hi = ~cur_hi;
    end else begin
      if (stall_left > 0) begin vco_tick = 0; stall_left--; end
      else vco_tick = 1;
      xph = (xph == 2) ? 0 : xph + 1;
      xtal_tick = (xph == 0);
    end
  endtask

  task automatic wait_vfall();
    int s;
    s = vf_seen;
    while (vf_seen == s) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int w, p0, guard;
    void'($urandom(32'd7741));
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(div_vco == 0 && div_ref == 0, "R12 dividers low", {div_vco, div_ref}, 0);
    chk(pump_up == 0 && pump_dn == 0, "R12 no command", {pump_up, pump_dn}, 0);
    chk(pump_hiz == 1, "R12 hiz", pump_hiz, 1);
    chk(locked == 0, "R12 unlocked", locked, 0);
    chk(pump_mag == 3'd1, "R9 mag at reset", pump_mag, 1);
    n_word = 11'd1500;
    rst_n = 1'b1;

    // random phase: R1-R4 under mixed tick rates and ratio changes
    repeat (60000) step();
    chk(vf_seen > 10, "R1 vco falls observed", vf_seen, 11);
    chk(rf_seen > 20, "R4 ref falls observed", rf_seen, 21);

    // fixed-rate phase for lock and directed phase offsets
    mode = 1; cur_hi = 1; n_word = 11'd1200;
    wait_vfall(); wait_vfall(); wait_vfall();
    up_end = 0; dn_end = 0; guard = 0;
    while (!up_end && !dn_end && guard < 2500) begin step(); guard++; end
    if (up_end) stall_left = up_end_w;
    else if (dn_end) stall_left = 1200 - dn_end_w;
    repeat (1300) step();
    p0 = pulses_seen;
    repeat (30000) step();
    chk(pulses_seen == p0, "R7 aligned edges give no command", pulses_seen - p0, 0);
    chk(locked == 1, "R11 lock after quiet refs", locked, 1);

    // lead by 3 cycles: R5
    wait_vfall(); n_word = 11'd1197;
    wait_vfall(); n_word = 11'd1200;
    up_end = 0;
    while (!up_end) step();
    chk(up_end_w == 3, "R5 up width equals lead", up_end_w, 3);
    chk(locked == 0, "R11 lock dropped by pulse", locked, 0);

    // lead 3 then lengthen by 5: lag 2, R6
    wait_vfall(); n_word = 11'd1205;
    wait_vfall(); n_word = 11'd1200;
    dn_end = 0;
    while (!dn_end) step();
    chk(dn_end_w == 2, "R6 dn width equals lag", dn_end_w, 2);
    repeat (50) step();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule